// File: doc/BRIEF.md
# Power-Fail Write-Protect Sequencer

This block supervises the control strobes between a host bus and a battery-backed byte-wide memory array. It watches two digital comparator flags: one says the supply has dropped under the deselect threshold, the other says it has dropped under the battery switchover threshold. While the supply is good, the host chip-enable reaches the array unchanged. When the supply starts to fail, the block locks out writes and tristates the bus. An access that is already running when the failure is seen may finish, but only within a bounded window. Below the switchover threshold the block selects the battery.

When the supply comes back, the lockout is kept for a long recovery interval before normal accesses resume. Reset enters the same recovery interval, so power-up behaves like a return of power. All time constants are parameters counted in clock ticks. A status output shows the current state, and a sticky flag records that an in-flight access had to be cut off.

Top module: `pfwp_sequencer`

## Requirements
- R1: During and after synchronous reset the state output reads 4 (recovering), the gated chip-enable is high (inactive), write-inhibit and bus-tristate are 1, battery-select and the cut-off flag are 0. With a good supply the state reads 0 (normal) exactly REC_TICKS clock cycles after reset is released.
- R2: In state 0 every output is registered, one cycle behind the host strobes (both active low). The gated chip-enable equals the host chip-enable, write-inhibit is 0, and bus-tristate is 0 only while the host chip-enable is low and write-enable is high (a read).
- R3: The comparator flags pass through a two-flop synchronizer. A deselect flag that is raised while no access is active moves the state from 0 to 2 (protected) on the third rising clock edge after it is applied, and write-inhibit goes to 1 on that same edge.
- R4: If the deselect flag is seen while the host chip-enable is low, the state becomes 1 (draining). The gated chip-enable stays low and write-inhibit stays 0 while the host keeps chip-enable low. Releasing chip-enable within WP_TICKS cycles of entering state 1 moves the state to 2 with the cut-off flag still 0.
- R5: An access still held after WP_TICKS cycles in state 1 is cut off: the state goes to 2 and the cut-off flag goes to 1. The flag stays at 1 until the next reset, including through recovery.
- R6: In states 2, 3 and 4, host strobes are ignored. The gated chip-enable stays high and write-inhibit and bus-tristate stay 1 for every combination of host chip-enable and write-enable.
- R7: A raised switchover flag moves the state to 3 (battery) and sets battery-select to 1. When the switchover flag falls, battery-select returns to 0 and the state moves to 2 while the deselect flag is still raised.
- R8: When the deselect flag falls, state 2 moves to state 4. State 4 holds for exactly REC_TICKS cycles and then moves to 0. If the deselect flag rises during state 4, the state returns to 2, and the next recovery starts its full interval again.
- R9: A switchover flag raised while an access is draining in state 1 moves the state directly to 3 and sets the cut-off flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vlow_i | input | 1 | Comparator: supply below deselect threshold (asynchronous) |
| vbat_i | input | 1 | Comparator: supply below battery switchover threshold (asynchronous) |
| host_ce_n_i | input | 1 | Host chip-enable, active low |
| host_we_n_i | input | 1 | Host write-enable, active low |
| mem_ce_n_o | output | 1 | Gated chip-enable to the array, active low |
| wr_inhibit_o | output | 1 | Write lockout, 1 = writes blocked |
| bus_hiz_o | output | 1 | 1 = data bus drivers tristated |
| bat_sel_o | output | 1 | 1 = array powered from the battery |
| state_o | output | 3 | Current state: 0 normal, 1 draining, 2 protected, 3 battery, 4 recovering |
| forced_o | output | 1 | Sticky: an in-flight access was cut off |

## Verification
Some properties are checked by assertions on every cycle. A new chip-enable may only begin from the normal state, and a drain never lasts longer than WP_TICKS cycles. Whenever the state is protected, battery or recovering, the outputs are in their locked-out values. Battery-select only rises after a synchronized switchover flag, and the cut-off flag never clears outside reset. Other behaviours can only be shown by the bench scenarios. These are the exact latency through the synchronizer, the split between a clean finish and a cut-off across all hold lengths around WP_TICKS, the exact recovery length, and the recovery restarting when the supply dips again.

// File: rtl/pfwp_pkg.sv
package pfwp_pkg;
  typedef enum logic [2:0] {
    PF_NORMAL  = 3'd0,
    PF_DRAIN   = 3'd1,
    PF_PROTECT = 3'd2,
    PF_BATTERY = 3'd3,
    PF_RECOVER = 3'd4
  } pf_state_e;
endpackage

// File: rtl/pfwp_sync.sv
module pfwp_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

  AST_SYNC_CHAIN: assert property (@(posedge clk) disable iff (rst)
    !$stable(q) |-> (q == $past(stg[STAGES-2]))); // R3
endmodule

// File: rtl/pfwp_tick_timer.sv
module pfwp_tick_timer #(
  parameter int CW = 8,
  parameter logic [CW-1:0] RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= RST_VAL;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt == '0) |=> (cnt == '0)); // R5
endmodule

// File: rtl/pfwp_sequencer.sv
module pfwp_sequencer #(
  parameter int WP_TICKS = 15000,
  parameter int REC_TICKS = 4000000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       vlow_i,
  input  logic       vbat_i,
  input  logic       host_ce_n_i,
  input  logic       host_we_n_i,
  output logic       mem_ce_n_o,
  output logic       wr_inhibit_o,
  output logic       bus_hiz_o,
  output logic       bat_sel_o,
  output logic [2:0] state_o,
  output logic       forced_o
);
  import pfwp_pkg::*;

  localparam int MAXT = (WP_TICKS > REC_TICKS) ? WP_TICKS : REC_TICKS;
  localparam int CW = $clog2(MAXT + 1);
  localparam logic [CW-1:0] WP_LOAD = CW'(WP_TICKS - 1);
  localparam logic [CW-1:0] REC_LOAD = CW'(REC_TICKS - 1);

  logic [1:0] flags_s;
  logic       vlow_s, vbat_s;
  pf_state_e  state_q, state_d;
  logic       cut_d, forced_q;
  logic       tmr_load, tmr_done;
  logic [CW-1:0] tmr_val;
  logic       grant;

  pfwp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({vbat_i, vlow_i}), .q(flags_s)
  );
  assign vlow_s = flags_s[0];
  assign vbat_s = flags_s[1];

  pfwp_tick_timer #(.CW(CW), .RST_VAL(REC_LOAD)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  always_comb begin
    state_d = state_q;
    cut_d   = 1'b0;
    unique case (state_q)
      PF_NORMAL: begin
        if (vbat_s)            state_d = PF_BATTERY;
        else if (vlow_s)       state_d = host_ce_n_i ? PF_PROTECT : PF_DRAIN;
      end
      PF_DRAIN: begin
        if (host_ce_n_i)       state_d = PF_PROTECT;
        else if (vbat_s) begin state_d = PF_BATTERY; cut_d = 1'b1; end
        else if (tmr_done) begin state_d = PF_PROTECT; cut_d = 1'b1; end
      end
      PF_PROTECT: begin
        if (vbat_s)            state_d = PF_BATTERY;
        else if (!vlow_s)      state_d = PF_RECOVER;
      end
      PF_BATTERY: begin
        if (!vbat_s)           state_d = PF_PROTECT;
      end
      PF_RECOVER: begin
        if (vbat_s)            state_d = PF_BATTERY;
        else if (vlow_s)       state_d = PF_PROTECT;
        else if (tmr_done)     state_d = PF_NORMAL;
      end
      default:                 state_d = PF_PROTECT;
    endcase
  end

  assign tmr_load = (state_d != state_q) &&
                    (state_d == PF_DRAIN || state_d == PF_RECOVER);
  assign tmr_val  = (state_d == PF_DRAIN) ? WP_LOAD : REC_LOAD;
  assign grant    = (state_d == PF_NORMAL || state_d == PF_DRAIN) && !host_ce_n_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= PF_RECOVER;
      mem_ce_n_o   <= 1'b1;
      wr_inhibit_o <= 1'b1;
      bus_hiz_o    <= 1'b1;
      bat_sel_o    <= 1'b0;
      forced_q     <= 1'b0;
    end else begin
      state_q      <= state_d;
      mem_ce_n_o   <= !grant;
      wr_inhibit_o <= !(state_d == PF_NORMAL || state_d == PF_DRAIN);
      bus_hiz_o    <= !(grant && host_we_n_i);
      bat_sel_o    <= (state_d == PF_BATTERY);
      forced_q     <= forced_q | cut_d;
    end
  end

  assign state_o  = state_q;
  assign forced_o = forced_q;

  logic [CW:0] drain_run;
  always_ff @(posedge clk) begin
    if (rst)                      drain_run <= '0;
    else if (state_q == PF_DRAIN) drain_run <= drain_run + 1'b1;
    else                          drain_run <= '0;
  end

  AST_NEW_ACCESS_FROM_NORMAL: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_ce_n_o) |-> ($past(state_q) == PF_NORMAL)); // R6
  AST_LOCKED_OUTPUTS: assert property (@(posedge clk) disable iff (rst)
    (state_q == PF_PROTECT || state_q == PF_BATTERY || state_q == PF_RECOVER)
      |-> (mem_ce_n_o && wr_inhibit_o && bus_hiz_o)); // R6
  AST_DRAIN_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    drain_run <= (CW+1)'(WP_TICKS)); // R5
  AST_BAT_AFTER_FLAG: assert property (@(posedge clk) disable iff (rst)
    $rose(bat_sel_o) |-> $past(vbat_s)); // R7
  AST_FORCED_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(forced_q) |-> forced_q); // R5
  AST_RECOVER_EXIT: assert property (@(posedge clk) disable iff (rst)
    (state_q == PF_NORMAL && $past(state_q) == PF_RECOVER) |-> $past(tmr_done)); // R8
  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    state_q <= PF_RECOVER); // R1
endmodule

// File: tb/tb_pfwp_sequencer.sv
module tb_pfwp_sequencer;
  localparam int WP = 6;
  localparam int REC = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vlow = 1'b0, vbat = 1'b0, ce_n = 1'b1, we_n = 1'b1;
  logic mem_ce_n, wr_inh, bus_hiz, bat_sel, forced;
  logic [2:0] st;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #2.5ns clk = ~clk;

  pfwp_sequencer #(.WP_TICKS(WP), .REC_TICKS(REC), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .vlow_i(vlow), .vbat_i(vbat),
    .host_ce_n_i(ce_n), .host_we_n_i(we_n),
    .mem_ce_n_o(mem_ce_n), .wr_inhibit_o(wr_inh), .bus_hiz_o(bus_hiz),
    .bat_sel_o(bat_sel), .state_o(st), .forced_o(forced)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic go_reset(output int rec_len);
    rst = 1'b1; vlow = 1'b0; vbat = 1'b0; ce_n = 1'b1; we_n = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rec_len = 0;
    while (st != 3'd0 && rec_len < 200) begin
      @(negedge clk);
      rec_len++;
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1ms;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n;
    // R1: reset values
    wait_n(3);
    chk("R1 state", st, 4);
    chk("R1 mem_ce_n", mem_ce_n, 1);
    chk("R1 inhibit", wr_inh, 1);
    chk("R1 hiz", bus_hiz, 1);
    chk("R1 bat_sel", bat_sel, 0);
    chk("R1 forced", forced, 0);
    go_reset(n);
    chk("R1 recovery length", n, REC);

    // R2: pass-through sweep
    for (int c = 0; c < 4; c++) begin
      ce_n = c[0]; we_n = c[1];
      @(negedge clk);
      chk("R2 mem_ce_n", mem_ce_n, c[0]);
      chk("R2 inhibit", wr_inh, 0);
      chk("R2 hiz", bus_hiz, (!c[0] && c[1]) ? 0 : 1);
    end

    // R3: synchronizer latency, idle bus
    ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
    vlow = 1'b1;
    wait_n(2);
    chk("R3 still normal", st, 0);
    chk("R3 inhibit low", wr_inh, 0);
    @(negedge clk);
    chk("R3 protected", st, 2);
    chk("R3 inhibit", wr_inh, 1);

    // R6: strobes ignored while protected
    for (int c = 0; c < 4; c++) begin
      ce_n = c[0]; we_n = c[1];
      @(negedge clk);
      chk("R6 prot mem_ce_n", mem_ce_n, 1);
      chk("R6 prot hiz", bus_hiz, 1);
      chk("R6 prot inhibit", wr_inh, 1);
    end
    ce_n = 1'b1; we_n = 1'b1;

    // R7: battery entry and exit
    vbat = 1'b1;
    wait_n(3);
    chk("R7 battery state", st, 3);
    chk("R7 bat_sel", bat_sel, 1);
    ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    chk("R6 battery mem_ce_n", mem_ce_n, 1);
    chk("R6 battery inhibit", wr_inh, 1);
    ce_n = 1'b1; we_n = 1'b1;
    vbat = 1'b0;
    wait_n(3);
    chk("R7 back to protect", st, 2);
    chk("R7 bat_sel off", bat_sel, 0);

    // R8: recovery, restart on a new dip, exact length
    vlow = 1'b0;
    wait_n(3);
    chk("R8 recovering", st, 4);
    wait_n(2);
    vlow = 1'b1;
    wait_n(3);
    chk("R8 dip returns to protect", st, 2);
    vlow = 1'b0;
    wait_n(3);
    chk("R8 recovering again", st, 4);
    n = 0;
    while (st != 3'd0 && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk("R8 recovery length", n, REC);

    // R4 and R5: hold-length sweep around the window
    for (int len = 0; len <= WP + 2; len++) begin
      go_reset(n);
      ce_n = 1'b0; we_n = 1'b0;
      @(negedge clk);
      vlow = 1'b1;
      wait_n(3);
      chk("R4 draining", st, 1);
      chk("R4 gated ce held", mem_ce_n, 0);
      chk("R4 write allowed", wr_inh, 0);
      wait_n(len);
      ce_n = 1'b1;
      @(negedge clk);
      chk("R4 protected after drain", st, 2);
      chk("R5 forced vs hold", forced, (len >= WP) ? 1 : 0);
      chk("R4 gated ce off", mem_ce_n, 1);
      vlow = 1'b0;
      wait_n(3);
      chk("R5 forced sticky", forced, (len >= WP) ? 1 : 0);
    end

    // R9: switchover during drain
    go_reset(n);
    ce_n = 1'b0; we_n = 1'b1;
    @(negedge clk);
    vlow = 1'b1;
    wait_n(3);
    chk("R9 draining", st, 1);
    vbat = 1'b1;
    wait_n(3);
    chk("R9 battery", st, 3);
    chk("R9 forced", forced, 1);
    chk("R9 bat_sel", bat_sel, 1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule